// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block produces the transmit clock that an Ethernet MAC drives towards its PHY over RGMII. It is built as a tick-driven engine in one system clock domain. Two parent clock enables come in as single-cycle ticks, and one of them is chosen as the source. A one-based integer divider turns the chosen ticks into an intermediate tick stream, whose nominal rate is 250 MHz. A fixed toggle stage halves that stream to the 125 MHz nominal transmit clock. A software enable gates the clock. A line-speed code then stretches each half-period by 1, 5 or 50, which gives 125, 25 or 2.5 MHz. A small delay field moves every edge later by whole intermediate periods.

The settings come from an 11-bit configuration word and a two-bit speed code:

| Field | Bits | Meaning |
|-------|------|---------|
| gate | 10 | 1 lets the clock run, 0 stops it low |
| div | 9:7 | one-based divide ratio |
| dly | 6:5 | edge delay in intermediate periods |
| src | 4 | parent select: 0 picks tick A, 1 picks tick B |
| — | 3:0 | unused |

Changes to the divide ratio, the gate and the speed are held back until the end of a low half-period, so the clock never shows a shortened pulse. The delay setting is taken only while the whole output path is idle and low.

Top module: `rgmii_txclk_gen`

## Requirements
- R1: Bit 4 of `cfg_i` chooses the parent tick. With 0, `par_tick_a_i` feeds the divider. With 1, `par_tick_b_i` feeds it.
- R2: Bits 9:7 of `cfg_i` hold a one-based ratio N. The divider issues one intermediate tick for every N selected parent ticks, so a value of 7 divides by seven.
- R3: A divide field of 0 acts as a ratio of 1, and the clock keeps running.
- R4: A fixed divide-by-two follows the divider. At gigabit speed each high or low phase of `tx_clk_o` lasts exactly one intermediate period.
- R5: Bit 10 of `cfg_i` enables the clock. With 0, the output finishes its current cycle, then stays low and stops toggling. Setting the bit back to 1 resumes the clock at the programmed rate.
- R6: The speed code sets the length of each half-period, measured in intermediate periods. Codes 2'b10 and 2'b11 give 1, code 2'b01 gives 5 and code 2'b00 gives 50.
- R7: Bits 6:5 of `cfg_i` hold a delay d from 0 to 3. Every output edge comes d intermediate periods later than it would with d = 0. The field is captured only while the output path is idle and low.
- R8: Changes to the divide ratio, the speed code or the gate take effect only at the end of a low half-period. Every high or low phase therefore has the length set by either the old settings or the new ones.
- R9: A synchronous active-high reset clears all counters. The output is low from the first clock edge at which reset is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| par_tick_a_i | input | 1 | Tick from parent clock A |
| par_tick_b_i | input | 1 | Tick from parent clock B |
| cfg_i | input | 11 | Configuration word: gate [10], div [9:7], dly [6:5], src [4] |
| speed_i | input | 2 | Line-speed code (2'b10 or 2'b11 gigabit, 2'b01 for 100M, 2'b00 for 10M) |
| tx_clk_o | output | 1 | Registered transmit clock |

## Verification
The output register adds one system cycle after the internal toggle. That cycle is the same for every edge, so phase lengths and delay offsets are measured as whole runs of system cycles, sampled on the falling edge.

A new setting appears only after the current low phase ends, which can take up to one old period. The bench therefore waits for four rising output edges before it arms the scoreboard, so the first phase it compares already runs at the new rate.

The delay is measured as the time from reset release to the first rising edge. Because the offset between two runs is compared, the pipeline latency cancels out. In the switching test each measured phase may match either the old length or the new one.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;

  // field positions inside the configuration word
  localparam int CFG_W        = 11;
  localparam int CFG_SRC_BIT  = 4;
  localparam int CFG_DLY_LSB  = 5;
  localparam int CFG_DIV_LSB  = 7;
  localparam int CFG_GATE_BIT = 10;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_1G_X = 2'b11
  } speed_e;

  // one-based divide ratio, a zero field counts as one
  function automatic int div_ratio(input int field);
    return (field == 0) ? 1 : field;
  endfunction

  // half-period length in intermediate periods for a speed code
  function automatic int half_mult(input logic [1:0] code, input int mid_f, input int slow_f);
    case (speed_e'(code))
      SPD_100M: return mid_f;
      SPD_10M:  return slow_f;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/rgtx_src_div.sv
module rgtx_src_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_field,
  input  logic             load,
  output logic             mid_tick,
  output logic [DIV_W-1:0] cnt_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_sel;
  logic [DIV_W-1:0] ratio_new;

  assign tick_sel  = src_sel ? tick_b : tick_a;
  assign ratio_new = DIV_W'(rgtx_pkg::div_ratio(int'(div_field)));
  assign mid_tick  = tick_sel && (cnt_q >= (ratio_q - ONE));
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= ratio_new;
    end else if (tick_sel) begin
      if (mid_tick) begin
        cnt_q <= '0;
        if (load) ratio_q <= ratio_new;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end
endmodule

// File: rtl/rgtx_half_gen.sv
module rgtx_half_gen #(
  parameter int MID_F  = 5,
  parameter int SLOW_F = 50,
  parameter int HC_W   = $clog2(SLOW_F)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mid_tick,
  input  logic [1:0]      spd_code,
  input  logic            gate_bit,
  output logic            raw_o,
  output logic            cfg_load,
  output logic            gate_q_o,
  output logic [1:0]      spd_q_o,
  output logic [HC_W-1:0] hcnt_o
);
  localparam logic [HC_W-1:0] ONE = HC_W'(1);

  logic [1:0]      spd_q;
  logic            gate_q;
  logic            raw_q;
  logic [HC_W-1:0] hcnt_q;
  logic [HC_W-1:0] half_lim;
  logic            half_end;

  assign half_lim = HC_W'(rgtx_pkg::half_mult(spd_q, MID_F, SLOW_F) - 1);
  assign half_end = mid_tick && (hcnt_q >= half_lim);
  assign cfg_load = half_end && !raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      hcnt_q <= '0;
      gate_q <= 1'b0;
      spd_q  <= spd_code;
    end else if (mid_tick) begin
      if (half_end) begin
        hcnt_q <= '0;
        if (raw_q) begin
          raw_q <= 1'b0;
        end else begin
          raw_q  <= gate_bit;
          gate_q <= gate_bit;
          spd_q  <= spd_code;
        end
      end else begin
        hcnt_q <= hcnt_q + ONE;
      end
    end
  end

  assign raw_o    = raw_q;
  assign gate_q_o = gate_q;
  assign spd_q_o  = spd_q;
  assign hcnt_o   = hcnt_q;
endmodule

// File: rtl/rgtx_phase_dly.sv
module rgtx_phase_dly #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mid_tick,
  input  logic             raw,
  input  logic [DLY_W-1:0] dly_field,
  output logic             tx_o,
  output logic             idle_o,
  output logic [DLY_W-1:0] dly_q_o
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic             dl_q [DEPTH];
  logic [DLY_W-1:0] dly_q;
  logic             tx_q;
  logic             tap;
  logic             any_dl;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)           dl_q[s] <= 1'b0;
        else if (mid_tick) dl_q[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)           dl_q[s] <= 1'b0;
        else if (mid_tick) dl_q[s] <= dl_q[s-1];
      end
    end
  end

  always_comb begin
    tap    = raw;
    any_dl = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      any_dl = any_dl | dl_q[k];
      if (int'(dly_q) == k + 1) tap = dl_q[k];
    end
  end

  assign idle_o = !raw && !any_dl && !tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= 1'b0;
      dly_q <= dly_field;
    end else begin
      tx_q <= tap;
      if (idle_o) dly_q <= dly_field;
    end
  end

  assign tx_o    = tx_q;
  assign dly_q_o = dly_q;
endmodule

// File: rtl/rgmii_txclk_gen.sv
module rgmii_txclk_gen #(
  parameter int DIV_W       = 3,
  parameter int DLY_W       = 2,
  parameter int MID_FACTOR  = 5,
  parameter int SLOW_FACTOR = 50
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      par_tick_a_i,
  input  logic                      par_tick_b_i,
  input  logic [rgtx_pkg::CFG_W-1:0] cfg_i,
  input  logic [1:0]                speed_i,
  output logic                      tx_clk_o
);
  localparam int HC_W = $clog2(SLOW_FACTOR);

  logic             src_sel;
  logic [DIV_W-1:0] div_field;
  logic [DLY_W-1:0] dly_field;
  logic             gate_bit;

  logic             mid_tick;
  logic             cfg_load;
  logic             raw;
  logic             gate_q;
  logic [1:0]       spd_q;
  logic [HC_W-1:0]  hcnt;
  logic [DIV_W-1:0] div_cnt;
  logic             idle;
  logic [DLY_W-1:0] dly_q;

  assign src_sel   = cfg_i[rgtx_pkg::CFG_SRC_BIT];
  assign div_field = cfg_i[rgtx_pkg::CFG_DIV_LSB +: DIV_W];
  assign dly_field = cfg_i[rgtx_pkg::CFG_DLY_LSB +: DLY_W];
  assign gate_bit  = cfg_i[rgtx_pkg::CFG_GATE_BIT];

  rgtx_src_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .tick_a    (par_tick_a_i),
    .tick_b    (par_tick_b_i),
    .src_sel   (src_sel),
    .div_field (div_field),
    .load      (cfg_load),
    .mid_tick  (mid_tick),
    .cnt_o     (div_cnt)
  );

  rgtx_half_gen #(.MID_F(MID_FACTOR), .SLOW_F(SLOW_FACTOR), .HC_W(HC_W)) u_half (
    .clk      (clk),
    .rst      (rst),
    .mid_tick (mid_tick),
    .spd_code (speed_i),
    .gate_bit (gate_bit),
    .raw_o    (raw),
    .cfg_load (cfg_load),
    .gate_q_o (gate_q),
    .spd_q_o  (spd_q),
    .hcnt_o   (hcnt)
  );

  rgtx_phase_dly #(.DLY_W(DLY_W)) u_dly (
    .clk       (clk),
    .rst       (rst),
    .mid_tick  (mid_tick),
    .raw       (raw),
    .dly_field (dly_field),
    .tx_o      (tx_clk_o),
    .idle_o    (idle),
    .dly_q_o   (dly_q)
  );
endmodule

// File: rtl/rgmii_txclk_gen_chk.sv
module rgmii_txclk_gen_chk #(
  parameter int DIV_W  = 3,
  parameter int DLY_W  = 2,
  parameter int HC_W   = 6,
  parameter int SLOW_F = 50
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_clk,
  input logic             raw,
  input logic             mid_tick,
  input logic             gate_q,
  input logic             idle,
  input logic [1:0]       spd_q,
  input logic [DLY_W-1:0] dly_q,
  input logic [DIV_W-1:0] div_cnt,
  input logic [HC_W-1:0]  hcnt
);
  assert_low_after_reset_R9: assert property (@(posedge clk) rst |=> !tx_clk);

  assert_toggle_on_mid_R4: assert property (@(posedge clk) disable iff (rst)
    (raw != $past(raw)) |-> $past(mid_tick));

  assert_rise_needs_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> gate_q);

  assert_idle_stays_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!gate_q && idle) |=> !tx_clk);

  assert_speed_at_low_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(spd_q) |-> !$past(raw));

  assert_delay_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dly_q) |-> !$past(tx_clk));

  assert_div_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(div_cnt) < (1 << DIV_W) - 1);

  assert_half_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(hcnt) < SLOW_F);
endmodule

bind rgmii_txclk_gen rgmii_txclk_gen_chk #(
  .DIV_W(DIV_W), .DLY_W(DLY_W), .HC_W(HC_W), .SLOW_F(SLOW_FACTOR)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tx_clk   (tx_clk_o),
  .raw      (raw),
  .mid_tick (mid_tick),
  .gate_q   (gate_q),
  .idle     (idle),
  .spd_q    (spd_q),
  .dly_q    (dly_q),
  .div_cnt  (div_cnt),
  .hcnt     (hcnt)
);

// File: tb/rgmii_txclk_gen_tb_top.sv
module rgmii_txclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_a = 1'b1;
  logic        tick_b = 1'b0;
  logic [10:0] cfg = '0;
  logic [1:0]  speed = 2'b10;
  logic        tx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit armed  = 1'b0;

  typedef struct {
    int    v1;
    int    v2;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  rgmii_txclk_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .par_tick_a_i (tick_a),
    .par_tick_b_i (tick_b),
    .cfg_i        (cfg),
    .speed_i      (speed),
    .tx_clk_o     (tx)
  );

  initial forever begin
    @(negedge clk);
    tick_b = ~tick_b;
  end

  // monitor: measures each completed high or low run and compares it
  int run_len = 0;
  logic prev_tx = 1'b0;
  initial forever begin
    @(negedge clk);
    if (rst) begin
      run_len = 0;
      prev_tx = tx;
    end else if (tx == prev_tx) begin
      run_len++;
    end else begin
      if (armed && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (run_len != e.v1 && run_len != e.v2) begin
          fails++;
          $display("FAIL %s: phase length %0d, expected %0d or %0d", e.tag, run_len, e.v1, e.v2);
        end
      end
      run_len = 1;
      prev_tx = tx;
    end
  end

  function automatic logic [10:0] mk_cfg(bit gate, int dv, int dl, bit src);
    logic [10:0] c;
    c = '0;
    c[10]  = gate;
    c[9:7] = 3'(dv);
    c[6:5] = 2'(dl);
    c[4]   = src;
    return c;
  endfunction

  // expected half-period in system cycles, from the requirements
  function automatic int exp_half(bit src, int dv, logic [1:0] spd);
    int step;
    int n;
    int m;
    step = src ? 2 : 1;
    n = (dv == 0) ? 1 : dv;
    m = (spd == 2'b01) ? 5 : (spd == 2'b00) ? 50 : 1;
    return step * n * m;
  endfunction

  task automatic wait_rises(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge tx);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    armed = 1'b0;
  endtask

  task automatic check_half(bit src, int dv, logic [1:0] spd, string tag);
    int h;
    @(negedge clk);
    cfg   = mk_cfg(1'b1, dv, 0, src);
    speed = spd;
    wait_rises(4);
    h = exp_half(src, dv, spd);
    for (int i = 0; i < 4; i++) exp_q.push_back('{h, h, tag});
    armed = 1'b1;
    drain();
  endtask

  task automatic first_rise(int dl, output int n);
    @(negedge clk);
    rst = 1'b1;
    cfg = mk_cfg(1'b1, 2, dl, 1'b0);
    speed = 2'b10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!tx) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got 0, expected 1");
      summary();
    end
  end

  initial begin
    int t0;
    int t2;
    int t3;
    int changes;
    repeat (5) @(negedge clk);
    chk(tx == 1'b0, "R9 reset output low", int'(tx), 0);
    rst = 1'b0;

    check_half(1'b0, 2, 2'b10, "R4 gigabit div2");
    check_half(1'b0, 0, 2'b10, "R3 zero field");
    check_half(1'b1, 5, 2'b10, "R1 source B div5");
    check_half(1'b0, 7, 2'b10, "R2 div7");
    check_half(1'b0, 3, 2'b11, "R6 code 11");
    check_half(1'b0, 2, 2'b01, "R6 100M");
    check_half(1'b0, 1, 2'b00, "R6 10M");

    // R5: gate off, output must settle low and stay there
    check_half(1'b0, 2, 2'b10, "R5 before gate off");
    @(negedge clk);
    cfg = mk_cfg(1'b0, 2, 0, 1'b0);
    repeat (60) @(negedge clk);
    changes = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx) changes++;
    end
    chk(changes == 0, "R5 gated output low", changes, 0);
    check_half(1'b0, 2, 2'b10, "R5 resume");

    // R8: switching speed mid-stream produces only old or new phase lengths
    check_half(1'b0, 1, 2'b10, "R8 setup");
    for (int i = 0; i < 8; i++) exp_q.push_back('{1, 5, "R8 no runt"});
    armed = 1'b1;
    @(negedge clk);
    speed = 2'b01;
    drain();
    check_half(1'b0, 1, 2'b01, "R8 new rate");

    // R7: edge delay measured against delay zero, intermediate period 2 cycles
    first_rise(0, t0);
    first_rise(2, t2);
    first_rise(3, t3);
    chk(t2 - t0 == 4, "R7 delay 2", t2 - t0, 4);
    chk(t3 - t0 == 6, "R7 delay 3", t3 - t0, 6);
    check_half(1'b0, 2, 2'b10, "R7 period kept with delay");

    // R9: reset in the middle of a running clock
    check_half(1'b0, 1, 2'b10, "R9 running");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(tx == 1'b0, "R9 mid-run reset", int'(tx), 0);
    @(negedge clk);
    chk(tx == 1'b0, "R9 held in reset", int'(tx), 0);
    rst = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule